// File: doc/BRIEF.md
# Core Voltage and Clock Mode Sequencer

This block sits next to a processor and turns a two-bit power-mode command into a safe, ordered change of core supply level and clock profile. Software presents the command together with a plane-control bit and pulses a strobe. The block then drives three things. The first is a one-bit request to the core regulator for the high or the low voltage. The second is a two-bit index into the four profiles stored in an external clock generator. The third is a line that keeps the processor halted for the whole change. A separate output switches the secondary power plane.

The order of the steps depends on the direction of the voltage change. When the supply must rise, the block raises it first and waits for the supply to report settled. Only then does it move the clock. When the supply falls or stays the same, the clock moves first, and the voltage follows once a fixed lock delay has passed. Commands that arrive during a change are held in a single slot and run once the change is over. The fourth command code carries no speed change. It only switches the secondary plane, and it takes effect at once.

Top module: `dvfs_seq_ctrl`

## Requirements
- R1: Command 2'b00 ends in vsel_hi_o=1 with profile 0. Command 2'b01 ends in vsel_hi_o=0 with profile 1. Command 2'b10 ends in vsel_hi_o=0 with profile 2. Profile 3 is never driven, and profile 0 only appears while vsel_hi_o=1.
- R2: Command and plane bits are taken only in the cycle where strobe_i is first seen high. A command that changes while the strobe stays high, or while it stays low, starts nothing.
- R3: Command 2'b11 copies plane_ctl_i to plane_en_o (1 = plane on) by the cycle after the strobe edge. This happens even in the middle of a sequence, and it neither disturbs that sequence nor replaces the pending speed command.
- R4: cpu_hold_o is 1 in every cycle in which vsel_hi_o or clk_prof_o differs from its value in the previous cycle. It returns to 0 when the sequence ends.
- R5: On a rise to the high voltage, vsel_hi_o changes first. The profile changes only after vsettled_i has risen again. The hold is released exactly LOCK_CYC cycles after the profile change.
- R6: On a fall to the low voltage, the profile changes first. vsel_hi_o drops exactly LOCK_CYC cycles later, and the hold is released after vsettled_i rises again.
- R7: Between two modes with the same voltage, vsel_hi_o does not toggle, and cpu_hold_o stays high for exactly LOCK_CYC cycles.
- R8: A speed command strobed during a sequence waits in one slot, where a later one replaces an earlier one. It runs after the current sequence ends.
- R9: A speed command equal to the current mode produces no hold pulse.
- R10: After reset the outputs are vsel_hi_o=1, profile 0, plane_en_o=1 and cpu_hold_o=1. The hold drops on the first cycle that vsettled_i is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Command strobe, taken on its rising edge |
| speed_cmd_i | input | 2 | Mode command (00 full, 01 medium, 10 low, 11 plane) |
| plane_ctl_i | input | 1 | Secondary plane request for command 11 |
| vsettled_i | input | 1 | Core supply settled indication |
| vsel_hi_o | output | 1 | Core voltage select, 1 = high level |
| clk_prof_o | output | 2 | Clock generator profile index |
| cpu_hold_o | output | 1 | Processor halt/reset, 1 = held |
| plane_en_o | output | 1 | Secondary power plane enable |

## Verification
Two functions can land on the same clock edge. The first is a plane-switch strobe or a new speed strobe arriving while a sequence is between steps. The second is the capture of a new command in the very cycle the sequencer takes the pending slot. The bench starts a long falling sequence, then strobes a medium command, a plane-off command and a full command back to back while the hold is still asserted. It judges the outcome on three points: the plane output changes at once while the hold stays up, exactly two hold pulses occur, and the final outputs match the last speed command rather than the discarded one.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    localparam int PROF_W = 2;

    localparam logic [1:0] CMD_FULL  = 2'b00;
    localparam logic [1:0] CMD_MED   = 2'b01;
    localparam logic [1:0] CMD_LOW   = 2'b10;
    localparam logic [1:0] CMD_PLANE = 2'b11;

    localparam logic [PROF_W-1:0] PROF_FULL = 2'd0;
    localparam logic [PROF_W-1:0] PROF_MED  = 2'd1;
    localparam logic [PROF_W-1:0] PROF_LOW  = 2'd2;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_RAISE,
        ST_LOCK_UP,
        ST_LOCK_DN,
        ST_LOWER
    } seq_st_e;

    typedef struct packed {
        seq_st_e           st;
        logic              vhi;
        logic [PROF_W-1:0] prof;
        logic              hold;
        logic              settled;
        logic [1:0]        mode;
    } seq_reg_t;

    typedef struct packed {
        logic       strb;
        logic       pend_v;
        logic [1:0] pend_cmd;
        logic       plane;
    } cap_reg_t;

endpackage

// File: rtl/dvfs_mode_map.sv
module dvfs_mode_map
    import dvfs_pkg::*;
(
    input  logic [1:0]        cmd_i,
    output logic              vhi_o,
    output logic [PROF_W-1:0] prof_o
);

    always_comb begin
        unique case (cmd_i)
            CMD_MED: begin
                vhi_o  = 1'b0;
                prof_o = PROF_MED;
            end
            CMD_LOW: begin
                vhi_o  = 1'b0;
                prof_o = PROF_LOW;
            end
            default: begin
                vhi_o  = 1'b1;
                prof_o = PROF_FULL;
            end
        endcase
    end

endmodule

// File: rtl/dvfs_lock_timer.sv
module dvfs_lock_timer #(
    parameter int LOCK_CYC = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic done_o
);

    localparam int CW = $clog2(LOCK_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(LOCK_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == CW'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/dvfs_cmd_latch.sv
module dvfs_cmd_latch
    import dvfs_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       strobe_i,
    input  logic [1:0] cmd_i,
    input  logic       plane_i,
    input  logic       take_i,
    output logic       pend_valid_o,
    output logic [1:0] pend_cmd_o,
    output logic       plane_en_o
);

    cap_reg_t r_d, r_q;
    logic     edge_seen;

    always_comb begin
        r_d       = r_q;
        r_d.strb  = strobe_i;
        edge_seen = strobe_i & ~r_q.strb;
        if (take_i) begin
            r_d.pend_v = 1'b0;
        end
        if (edge_seen) begin
            if (cmd_i == CMD_PLANE) begin
                r_d.plane = plane_i;
            end else begin
                r_d.pend_v   = 1'b1;
                r_d.pend_cmd = cmd_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.strb     <= 1'b0;
            r_q.pend_v   <= 1'b0;
            r_q.pend_cmd <= CMD_FULL;
            r_q.plane    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend_valid_o = r_q.pend_v;
    assign pend_cmd_o   = r_q.pend_cmd;
    assign plane_en_o   = r_q.plane;

    assert_plane_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(strobe_i) && cmd_i == CMD_PLANE) |=> (plane_en_o == $past(plane_i)))
        else $error("plane enable did not follow plane command");

    assert_pend_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(strobe_i) && cmd_i != CMD_PLANE) |=> (pend_valid_o && pend_cmd_o == $past(cmd_i)))
        else $error("speed command not held in pending slot");

endmodule

// File: rtl/dvfs_seq_ctrl.sv
module dvfs_seq_ctrl
    import dvfs_pkg::*;
#(
    parameter int LOCK_CYC = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       strobe_i,
    input  logic [1:0] speed_cmd_i,
    input  logic       plane_ctl_i,
    input  logic       vsettled_i,
    output logic       vsel_hi_o,
    output logic [1:0] clk_prof_o,
    output logic       cpu_hold_o,
    output logic       plane_en_o
);

    seq_reg_t          s_d, s_q;
    logic              pend_v;
    logic [1:0]        pend_cmd;
    logic              take;
    logic              tmr_start;
    logic              tmr_done;
    logic              settled_rise;
    logic              new_vhi, cur_vhi;
    logic [PROF_W-1:0] new_prof, cur_prof;

    dvfs_cmd_latch u_latch (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .strobe_i     (strobe_i),
        .cmd_i        (speed_cmd_i),
        .plane_i      (plane_ctl_i),
        .take_i       (take),
        .pend_valid_o (pend_v),
        .pend_cmd_o   (pend_cmd),
        .plane_en_o   (plane_en_o)
    );

    dvfs_mode_map u_map_new (
        .cmd_i  (pend_cmd),
        .vhi_o  (new_vhi),
        .prof_o (new_prof)
    );

    dvfs_mode_map u_map_cur (
        .cmd_i  (s_q.mode),
        .vhi_o  (cur_vhi),
        .prof_o (cur_prof)
    );

    dvfs_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (tmr_start),
        .done_o  (tmr_done)
    );

    always_comb begin
        s_d          = s_q;
        s_d.settled  = vsettled_i;
        settled_rise = vsettled_i & ~s_q.settled;
        take         = 1'b0;
        tmr_start    = 1'b0;
        unique case (s_q.st)
            ST_BOOT: begin
                if (vsettled_i) begin
                    s_d.hold = 1'b0;
                    s_d.st   = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (pend_v) begin
                    take = 1'b1;
                    if (pend_cmd != s_q.mode) begin
                        s_d.mode = pend_cmd;
                        s_d.hold = 1'b1;
                        if (new_vhi && !s_q.vhi) begin
                            s_d.vhi = 1'b1;
                            s_d.st  = ST_RAISE;
                        end else begin
                            s_d.prof  = new_prof;
                            tmr_start = 1'b1;
                            s_d.st    = ST_LOCK_DN;
                        end
                    end
                end
            end
            ST_RAISE: begin
                if (settled_rise) begin
                    s_d.prof  = cur_prof;
                    tmr_start = 1'b1;
                    s_d.st    = ST_LOCK_UP;
                end
            end
            ST_LOCK_UP: begin
                if (tmr_done) begin
                    s_d.hold = 1'b0;
                    s_d.st   = ST_IDLE;
                end
            end
            ST_LOCK_DN: begin
                if (tmr_done) begin
                    if (s_q.vhi != cur_vhi) begin
                        s_d.vhi = cur_vhi;
                        s_d.st  = ST_LOWER;
                    end else begin
                        s_d.hold = 1'b0;
                        s_d.st   = ST_IDLE;
                    end
                end
            end
            ST_LOWER: begin
                if (settled_rise) begin
                    s_d.hold = 1'b0;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.st      <= ST_BOOT;
            s_q.vhi     <= 1'b1;
            s_q.prof    <= PROF_FULL;
            s_q.hold    <= 1'b1;
            s_q.settled <= 1'b0;
            s_q.mode    <= CMD_FULL;
        end else begin
            s_q <= s_d;
        end
    end

    assign vsel_hi_o  = s_q.vhi;
    assign clk_prof_o = s_q.prof;
    assign cpu_hold_o = s_q.hold;

    assert_held_on_change_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(vsel_hi_o) || !$stable(clk_prof_o)) |-> cpu_hold_o)
        else $error("supply or clock moved with processor running");

    assert_raise_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vsel_hi_o) |-> $stable(clk_prof_o))
        else $error("clock moved together with voltage rise");

    assert_lower_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(vsel_hi_o) |-> ($stable(clk_prof_o) && cpu_hold_o))
        else $error("voltage fall not after clock change");

    assert_fast_needs_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_prof_o == PROF_FULL) |-> vsel_hi_o)
        else $error("fastest profile at low voltage");

    assert_no_spare_profile_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clk_prof_o != 2'b11)
        else $error("unused profile driven");

endmodule

// File: tb/sim_dvfs_seq_ctrl.sv
module sim_dvfs_seq_ctrl;

    localparam int L    = 8;
    localparam int RAMP = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic       pctl = 1'b1;
    logic       settled = 1'b0;
    logic       vsel_hi;
    logic [1:0] prof;
    logic       hold;
    logic       plane_en;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;
    bit boot_go = 0;
    bit mon_en = 0;

    int cyc = 0;
    int t_prof = 0, t_vsel = 0, t_rise = 0, t_fall = 0, hold_len = 0;
    int pulses = 0, unheld = 0;

    always #5 clk = ~clk;

    dvfs_seq_ctrl #(.LOCK_CYC(L)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .strobe_i    (strobe),
        .speed_cmd_i (cmd),
        .plane_ctl_i (pctl),
        .vsettled_i  (settled),
        .vsel_hi_o   (vsel_hi),
        .clk_prof_o  (prof),
        .cpu_hold_o  (hold),
        .plane_en_o  (plane_en)
    );

    // supply model: settled drops when the requested level moves, returns after RAMP cycles
    initial begin
        logic last_v;
        int   rc;
        rc = 0;
        wait (boot_go);
        @(negedge clk);
        settled = 1'b1;
        last_v  = vsel_hi;
        forever begin
            @(negedge clk);
            if (vsel_hi != last_v) begin
                last_v  = vsel_hi;
                settled = 1'b0;
                rc      = RAMP;
            end else if (rc > 0) begin
                rc = rc - 1;
                if (rc == 0) settled = 1'b1;
            end
        end
    end

    // output monitor
    initial begin
        logic pv, ph;
        logic [1:0] pp;
        wait (mon_en);
        @(negedge clk);
        pv = vsel_hi; pp = prof; ph = hold;
        forever begin
            @(negedge clk);
            cyc++;
            if (vsel_hi != pv) begin t_vsel = cyc; if (!hold) unheld++; end
            if (prof != pp)    begin t_prof = cyc; if (!hold) unheld++; end
            if (hold && !ph)   begin t_rise = cyc; pulses++; end
            if (!hold && ph)   begin t_fall = cyc; hold_len = cyc - t_rise; end
            pv = vsel_hi; pp = prof; ph = hold;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] c, input logic p);
        @(negedge clk);
        cmd = c; pctl = p; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic wait_quiet();
        int lowrun;
        lowrun = 0;
        for (int i = 0; i < 2000 && lowrun < 3; i++) begin
            @(negedge clk);
            lowrun = hold ? 0 : lowrun + 1;
        end
        chk(lowrun >= 3, "sequence end", lowrun, 3);
    endtask

    task automatic t_reset_boot();
        repeat (5) @(negedge clk);
        chk(hold == 1'b1, "R10 hold in reset", hold, 1);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(hold == 1'b1 && vsel_hi == 1'b1, "R10 hold until settled", {hold, vsel_hi}, 3);
        chk(prof == 2'd0, "R10 reset profile", prof, 0);
        chk(plane_en == 1'b1, "R10 reset plane", plane_en, 1);
        mon_en  = 1;
        boot_go = 1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(hold == 1'b0, "R10 release on settled", hold, 0);
        wait_quiet();
    endtask

    task automatic t_full_to_low();
        send(2'b10, 1'b1);
        wait_quiet();
        chk(vsel_hi == 1'b0 && prof == 2'd2, "R1 low mode outputs", {vsel_hi, prof}, 2);
        chk(t_vsel - t_prof == L, "R6 clock before voltage", t_vsel - t_prof, L);
        chk(t_fall > t_vsel + RAMP, "R6 release after settle", t_fall - t_vsel, RAMP + 1);
        chk(unheld == 0, "R4 changes held", unheld, 0);
    endtask

    task automatic t_low_to_med();
        int tv;
        tv = t_vsel;
        send(2'b01, 1'b1);
        wait_quiet();
        chk(vsel_hi == 1'b0 && prof == 2'd1, "R1 medium mode outputs", {vsel_hi, prof}, 1);
        chk(hold_len == L, "R7 equal-voltage hold length", hold_len, L);
        chk(t_vsel == tv, "R7 voltage untouched", t_vsel, tv);
    endtask

    task automatic t_med_to_full();
        send(2'b00, 1'b1);
        wait_quiet();
        chk(vsel_hi == 1'b1 && prof == 2'd0, "R1 full mode outputs", {vsel_hi, prof}, 4);
        chk(t_prof - t_vsel > RAMP, "R5 voltage settles before clock", t_prof - t_vsel, RAMP + 1);
        chk(t_fall - t_prof == L, "R5 release after lock", t_fall - t_prof, L);
        chk(unheld == 0, "R4 changes held", unheld, 0);
    endtask

    task automatic t_same_mode();
        int p0;
        p0 = pulses;
        send(2'b00, 1'b1);
        repeat (20) @(negedge clk);
        chk(pulses == p0, "R9 no hold for same mode", pulses, p0);
    endtask

    task automatic t_strobe_level();
        int p0;
        p0 = pulses;
        @(negedge clk);
        cmd = 2'b10;
        repeat (8) @(negedge clk);
        chk(pulses == p0 && prof == 2'd0, "R2 no strobe no capture", pulses, p0);
        cmd = 2'b00; strobe = 1'b1;
        @(negedge clk);
        cmd = 2'b10;
        repeat (10) @(negedge clk);
        strobe = 1'b0;
        repeat (20) @(negedge clk);
        chk(pulses == p0 && prof == 2'd0, "R2 held strobe takes once", pulses, p0);
    endtask

    task automatic t_plane();
        send(2'b11, 1'b0);
        chk(plane_en == 1'b0, "R3 plane off", plane_en, 0);
        repeat (3) @(negedge clk);
        chk(hold == 1'b0, "R3 plane cmd no sequence", hold, 0);
        send(2'b11, 1'b1);
        chk(plane_en == 1'b1, "R3 plane on", plane_en, 1);
    endtask

    task automatic t_pending_overlap();
        int p0;
        p0 = pulses;
        send(2'b10, 1'b1);
        repeat (2) @(negedge clk);
        send(2'b01, 1'b1);
        send(2'b11, 1'b0);
        chk(plane_en == 1'b0 && hold == 1'b1, "R3 plane mid-sequence", {plane_en, hold}, 1);
        send(2'b00, 1'b1);
        wait_quiet();
        chk(pulses - p0 == 2, "R8 latest pending only", pulses - p0, 2);
        chk(vsel_hi == 1'b1 && prof == 2'd0, "R8 final mode full", {vsel_hi, prof}, 4);
        chk(plane_en == 1'b0, "R3 plane kept", plane_en, 0);
        chk(unheld == 0, "R4 changes held", unheld, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        t_reset_boot();
        t_full_to_low();
        t_low_to_med();
        t_med_to_full();
        t_same_mode();
        t_strobe_level();
        t_plane();
        t_pending_overlap();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule